// File: doc/BRIEF.md
# Data-cache maintenance command unit

This block carries out maintenance commands on the line state of a small write-back data cache that is set-associative, indexed by virtual address and tagged by physical address. It keeps the valid, dirty and tag arrays of the cache itself. Software drives it through a small register file. A command can invalidate or write back one line chosen by tag and index, or it can invalidate or write back the whole cache. Dirty lines are handed out one at a time on a request/acknowledge writeback port.

Line commands take their two halves from two registers. The physical tag is written to a tag register first. A write of the virtual address to one of the line-command registers then supplies the set index and starts the command. Invalidate commands obey a mode bit in the control register. With the bit clear, a dirty line is discarded. With it set, the line is written back first, and the bit returns to zero when that invalidate command completes. The busy output stays high until the last writeback is acknowledged. While the unit is busy, register writes are stalled, not dropped.

Register addresses on `reg_addr`: 0 control (bit 0 = invalidate mode), 1 physical tag, 2 line invalidate, 3 line writeback, 4 whole-cache invalidate, 5 whole-cache writeback. The cache-state fill and probe ports stand in for the surrounding cache pipeline.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset every line is invalid and clean, the invalidate mode bit is 0, busy is 0, reg_ready is 1 and wb_req is 0.
- R2: A line invalidate with mode 0 clears the valid bit of the matching way and issues no writeback, even if that line is dirty.
- R3: A line or whole-cache invalidate with mode 1 writes back each dirty line it invalidates before clearing it. The mode bit reads 0 once any invalidate command completes.
- R4: A line writeback writes back a dirty matching line, then leaves it valid and clean. A clean matching line produces no writeback.
- R5: A line command whose indexed set holds no valid way with a tag equal to the tag register changes no line and issues no writeback.
- R6: Writing 1 to the whole-cache writeback register writes back every dirty line in ascending order, with the set as the major key and the way as the minor key. Every line is left clean and keeps its valid state.
- R7: Writing 1 to the whole-cache invalidate register leaves every line invalid. With mode 0 this issues no writeback.
- R8: busy rises in the cycle after a command is accepted and falls only after the last writeback acknowledge. While busy is high, reg_ready is 0 and a pending register write is held until it is accepted.
- R9: wb_req, once raised, stays high with wb_set, wb_way and wb_tag unchanged until the cycle in which wb_ack is sampled high.
- R10: A write of any value other than 1 to either whole-cache register starts nothing.
- R11: The line index is taken from reg_wdata bits [OFF_W+IDX_W-1:OFF_W] (bits 8:5 with the defaults). Offset bits and bits above the index are ignored. The tag compared is the low TAG_W bits of the tag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Write accepted at this edge when high |
| inv_mode | output | 1 | Invalidate mode bit (1 = write back before discard) |
| busy | output | 1 | Command in progress |
| fill_en | input | 1 | Install a line (taken only while idle) |
| fill_set | input | IDX_W | Set of the installed line |
| fill_way | input | WAY_W | Way of the installed line |
| fill_tag | input | TAG_W | Tag of the installed line |
| fill_dirty | input | 1 | Dirty state of the installed line |
| probe_set | input | IDX_W | Set to observe |
| probe_way | input | WAY_W | Way to observe |
| probe_valid | output | 1 | Valid bit of the observed line |
| probe_dirty | output | 1 | Dirty bit of the observed line |
| probe_tag | output | TAG_W | Tag of the observed line |
| wb_req | output | 1 | Writeback request |
| wb_ack | input | 1 | Writeback acknowledge |
| wb_set | output | IDX_W | Set of the line to write back |
| wb_way | output | WAY_W | Way of the line to write back |
| wb_tag | output | TAG_W | Tag of the line to write back |

## Verification
Each line command is tried on a line that is dirty and on one that is clean, under both invalidate modes and with both a matching and a mismatching tag. This separates discard from write-then-discard, and a real hit from a miss. The whole-cache commands run on sets whose dirty lines are scattered out of order and mixed with clean lines, so the writeback order and the skipping of clean lines both show at the port. A slow acknowledge keeps the unit busy while a further command is queued. This tells a stalled write apart from a dropped one.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL     = 3'd0,
      RA_PTAG     = 3'd1,
      RA_LINE_INV = 3'd2,
      RA_LINE_WB  = 3'd3,
      RA_ALL_INV  = 3'd4,
      RA_ALL_WB   = 3'd5
   } reg_addr_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_ACT,
      ST_WB
   } seq_state_e;
endpackage

// File: rtl/cmu_tag_store.sv
module cmu_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IDX_W-1:0]           rd_set,
   output logic [WAYS-1:0]            rd_valid,
   output logic [WAYS-1:0]            rd_dirty,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
   input  logic [IDX_W-1:0]           pr_set,
   input  logic [WAY_W-1:0]           pr_way,
   output logic                       pr_valid,
   output logic                       pr_dirty,
   output logic [TAG_W-1:0]           pr_tag,
   input  logic                       upd_en,
   input  logic [IDX_W-1:0]           upd_set,
   input  logic [WAY_W-1:0]           upd_way,
   input  logic                       upd_inval,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_set,
   input  logic [WAY_W-1:0]           fill_way,
   input  logic [TAG_W-1:0]           fill_tag,
   input  logic                       fill_dirty
);
   logic [WAYS-1:0]            pv_w;
   logic [WAYS-1:0]            pd_w;
   logic [WAYS-1:0][TAG_W-1:0] pt_w;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vbit;
      logic [SETS-1:0]  dbit;
      logic [TAG_W-1:0] tagm [SETS];
      logic             upd_here;
      logic             fill_here;

      assign upd_here  = upd_en  && (upd_way  == WAY_W'(w));
      assign fill_here = fill_en && (fill_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vbit <= '0;
            dbit <= '0;
            for (int s = 0; s < SETS; s++) tagm[s] <= '0;
         end else begin
            if (fill_here) begin
               vbit[fill_set] <= 1'b1;
               dbit[fill_set] <= fill_dirty;
               tagm[fill_set] <= fill_tag;
            end
            if (upd_here) begin
               dbit[upd_set] <= 1'b0;
               if (upd_inval) vbit[upd_set] <= 1'b0;
            end
         end
      end

      assign rd_valid[w] = vbit[rd_set];
      assign rd_dirty[w] = dbit[rd_set];
      assign rd_tag[w]   = tagm[rd_set];
      assign pv_w[w]     = vbit[pr_set];
      assign pd_w[w]     = dbit[pr_set];
      assign pt_w[w]     = tagm[pr_set];
   end

   assign pr_valid = pv_w[pr_way];
   assign pr_dirty = pd_w[pr_way];
   assign pr_tag   = pt_w[pr_way];
endmodule

// File: rtl/cmu_way_match.sv
module cmu_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            valid,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           ref_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = valid[w] && (tags[w] == ref_tag);
   end

   always_comb begin
      hit     = |eq;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (eq[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/cmu_seq.sv
module cmu_seq
   import cmu_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_line,
   input  logic             start_all,
   input  logic             start_inv,
   input  logic [IDX_W-1:0] start_set,
   input  logic             mode,
   input  logic             hit,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             cur_valid,
   input  logic             cur_dirty,
   input  logic             wb_ack,
   output logic             busy,
   output logic [IDX_W-1:0] cur_set,
   output logic [WAY_W-1:0] cur_way,
   output logic             wb_req,
   output logic             upd_en,
   output logic             upd_inval,
   output logic             done_inv
);
   localparam int CUR_W = IDX_W + WAY_W;

   seq_state_e       state;
   logic [CUR_W-1:0] cursor;
   logic             op_inv;
   logic             walk;
   logic             need_wb;
   logic             go_wb;
   logic             step;
   logic             more;

   assign cur_set = cursor[CUR_W-1:WAY_W];
   assign cur_way = cursor[WAY_W-1:0];

   always_comb begin
      need_wb   = op_inv ? mode : 1'b1;
      go_wb     = (state == ST_ACT) && cur_valid && cur_dirty && need_wb;
      step      = ((state == ST_ACT) && !go_wb) || ((state == ST_WB) && wb_ack);
      more      = walk && !(&cursor);
      upd_en    = ((state == ST_ACT) && !go_wb && cur_valid) || ((state == ST_WB) && wb_ack);
      upd_inval = op_inv;
      wb_req    = (state == ST_WB);
      busy      = (state != ST_IDLE);
      done_inv  = op_inv && (((state == ST_LOOK) && !hit) || (step && !more));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cursor <= '0;
         op_inv <= 1'b0;
         walk   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_line) begin
                  cursor <= {start_set, {WAY_W{1'b0}}};
                  op_inv <= start_inv;
                  walk   <= 1'b0;
                  state  <= ST_LOOK;
               end else if (start_all) begin
                  cursor <= '0;
                  op_inv <= start_inv;
                  walk   <= 1'b1;
                  state  <= ST_ACT;
               end
            end
            ST_LOOK: begin
               if (hit) begin
                  cursor[WAY_W-1:0] <= hit_way;
                  state             <= ST_ACT;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_ACT, ST_WB: begin
               if (go_wb) begin
                  state <= ST_WB;
               end else if (step) begin
                  if (more) begin
                     cursor <= cursor + CUR_W'(1);
                     state  <= ST_ACT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
   import cmu_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int TAG_W      = 20,
   parameter int LINE_BYTES = 32,
   parameter int DATA_W     = 32,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int OFF_W = $clog2(LINE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              reg_ready,
   output logic              inv_mode,
   output logic              busy,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              fill_dirty,
   input  logic [IDX_W-1:0]  probe_set,
   input  logic [WAY_W-1:0]  probe_way,
   output logic              probe_valid,
   output logic              probe_dirty,
   output logic [TAG_W-1:0]  probe_tag,
   output logic              wb_req,
   input  logic              wb_ack,
   output logic [IDX_W-1:0]  wb_set,
   output logic [WAY_W-1:0]  wb_way,
   output logic [TAG_W-1:0]  wb_tag
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      initial $fatal(1, "WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      initial $fatal(1, "SETS must be a power of two of at least 2");
   end
   if (OFF_W + IDX_W > DATA_W || TAG_W > DATA_W) begin : g_bad_width
      initial $fatal(1, "index or tag does not fit the register width");
   end

   logic                       wr_ok;
   logic                       is_line;
   logic                       is_all;
   logic                       start_line;
   logic                       start_all;
   logic                       start_inv;
   logic [IDX_W-1:0]           start_set;
   logic [TAG_W-1:0]           ptag_q;
   logic                       mode_q;
   logic                       done_inv;
   logic [IDX_W-1:0]           cur_set;
   logic [WAY_W-1:0]           cur_way;
   logic [WAYS-1:0]            set_valid;
   logic [WAYS-1:0]            set_dirty;
   logic [WAYS-1:0][TAG_W-1:0] set_tag;
   logic                       hit;
   logic [WAY_W-1:0]           hit_way;
   logic                       upd_en;
   logic                       upd_inval;

   assign reg_ready  = !busy;
   assign wr_ok      = reg_wr_en && reg_ready;
   assign is_line    = (reg_addr == RA_LINE_INV) || (reg_addr == RA_LINE_WB);
   assign is_all     = (reg_addr == RA_ALL_INV)  || (reg_addr == RA_ALL_WB);
   assign start_line = wr_ok && is_line;
   assign start_all  = wr_ok && is_all && (reg_wdata == DATA_W'(1));
   assign start_inv  = (reg_addr == RA_LINE_INV) || (reg_addr == RA_ALL_INV);
   assign start_set  = reg_wdata[OFF_W +: IDX_W];
   assign inv_mode   = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptag_q <= '0;
         mode_q <= 1'b0;
      end else begin
         if (wr_ok && reg_addr == RA_PTAG) ptag_q <= reg_wdata[TAG_W-1:0];
         if (wr_ok && reg_addr == RA_CTRL) mode_q <= reg_wdata[0];
         else if (done_inv)                mode_q <= 1'b0;
      end
   end

   cmu_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (cur_set),
      .rd_valid  (set_valid),
      .rd_dirty  (set_dirty),
      .rd_tag    (set_tag),
      .pr_set    (probe_set),
      .pr_way    (probe_way),
      .pr_valid  (probe_valid),
      .pr_dirty  (probe_dirty),
      .pr_tag    (probe_tag),
      .upd_en    (upd_en),
      .upd_set   (cur_set),
      .upd_way   (cur_way),
      .upd_inval (upd_inval),
      .fill_en   (fill_en && !busy),
      .fill_set  (fill_set),
      .fill_way  (fill_way),
      .fill_tag  (fill_tag),
      .fill_dirty(fill_dirty)
   );

   cmu_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .valid  (set_valid),
      .tags   (set_tag),
      .ref_tag(ptag_q),
      .hit    (hit),
      .hit_way(hit_way)
   );

   cmu_seq #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_line(start_line),
      .start_all (start_all),
      .start_inv (start_inv),
      .start_set (start_set),
      .mode      (mode_q),
      .hit       (hit),
      .hit_way   (hit_way),
      .cur_valid (set_valid[cur_way]),
      .cur_dirty (set_dirty[cur_way]),
      .wb_ack    (wb_ack),
      .busy      (busy),
      .cur_set   (cur_set),
      .cur_way   (cur_way),
      .wb_req    (wb_req),
      .upd_en    (upd_en),
      .upd_inval (upd_inval),
      .done_inv  (done_inv)
   );

   assign wb_set = cur_set;
   assign wb_way = cur_way;
   assign wb_tag = set_tag[cur_way];
endmodule

// File: rtl/cache_maint_unit_chk.sv
module cache_maint_unit_chk
   import cmu_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int WAY_W  = 2,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_ready,
   input logic              inv_mode,
   input logic              busy,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [IDX_W-1:0]  wb_set,
   input logic [WAY_W-1:0]  wb_way,
   input logic [TAG_W-1:0]  wb_tag
);
   logic acc;
   logic acc_line;
   logic acc_all_one;
   logic acc_all_other;
   logic acc_inv;
   logic discard_op;
   logic inv_op;

   assign acc           = reg_wr_en && reg_ready;
   assign acc_line      = acc && (reg_addr == RA_LINE_INV || reg_addr == RA_LINE_WB);
   assign acc_all_one   = acc && (reg_addr == RA_ALL_INV || reg_addr == RA_ALL_WB) && reg_wdata == DATA_W'(1);
   assign acc_all_other = acc && (reg_addr == RA_ALL_INV || reg_addr == RA_ALL_WB) && reg_wdata != DATA_W'(1);
   assign acc_inv       = (reg_addr == RA_LINE_INV || reg_addr == RA_ALL_INV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         discard_op <= 1'b0;
         inv_op     <= 1'b0;
      end else if (acc_line || acc_all_one) begin
         discard_op <= acc_inv && !inv_mode;
         inv_op     <= acc_inv;
      end else if (!busy) begin
         discard_op <= 1'b0;
      end
   end

   // R8
   cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_line || acc_all_one) |=> busy);

   // R8
   wb_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> busy);

   // R9
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_set) && $stable(wb_way) && $stable(wb_tag)));

   // R2
   discard_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discard_op |-> !wb_req);

   // R10
   bad_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_all_other |=> !busy);

   // R3
   mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && inv_op) |-> !inv_mode);
endmodule

bind cache_maint_unit cache_maint_unit_chk #(
   .IDX_W (IDX_W),
   .WAY_W (WAY_W),
   .TAG_W (TAG_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr_en(reg_wr_en),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_ready(reg_ready),
   .inv_mode (inv_mode),
   .busy     (busy),
   .wb_req   (wb_req),
   .wb_ack   (wb_ack),
   .wb_set   (wb_set),
   .wb_way   (wb_way),
   .wb_tag   (wb_tag)
);

// File: tb/cache_maint_unit_tb.sv
module cache_maint_unit_tb;
   localparam int SETS  = 16;
   localparam int WAYS  = 4;
   localparam int TAG_W = 20;
   localparam int IDX_W = 4;
   localparam int WAY_W = 2;

   localparam logic [2:0] A_CTRL = 3'd0, A_PTAG = 3'd1, A_LINV = 3'd2,
                          A_LWB = 3'd3, A_AINV = 3'd4, A_AWB = 3'd5;

   // fields: {inv, mode, dirty, match, exp_wb, exp_valid, exp_dirty}
   localparam logic [6:0] VEC [8] = '{
      7'b1011000, 7'b1001000, 7'b1111100, 7'b1101000,
      7'b0011110, 7'b0001010, 7'b0010011, 7'b1110011};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr_en = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic             reg_ready, inv_mode, busy;
   logic             fill_en = 1'b0;
   logic [IDX_W-1:0] fill_set = '0;
   logic [WAY_W-1:0] fill_way = '0;
   logic [TAG_W-1:0] fill_tag = '0;
   logic             fill_dirty = 1'b0;
   logic [IDX_W-1:0] probe_set = '0;
   logic [WAY_W-1:0] probe_way = '0;
   logic             probe_valid, probe_dirty;
   logic [TAG_W-1:0] probe_tag;
   logic             wb_req;
   logic             wb_ack = 1'b0;
   logic [IDX_W-1:0] wb_set;
   logic [WAY_W-1:0] wb_way;
   logic [TAG_W-1:0] wb_tag;

   int checks = 0;
   int errors = 0;
   int ack_delay = 1;
   int ack_wait = 0;
   int wb_n = 0;
   logic [IDX_W-1:0] log_set [64];
   logic [WAY_W-1:0] log_way [64];
   logic [TAG_W-1:0] log_tag [64];

   always #5 clk = ~clk;

   cache_maint_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ready(reg_ready), .inv_mode(inv_mode), .busy(busy),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
      .fill_dirty(fill_dirty), .probe_set(probe_set), .probe_way(probe_way),
      .probe_valid(probe_valid), .probe_dirty(probe_dirty), .probe_tag(probe_tag),
      .wb_req(wb_req), .wb_ack(wb_ack), .wb_set(wb_set), .wb_way(wb_way), .wb_tag(wb_tag));

   // writeback responder
   initial forever begin
      @(negedge clk);
      wb_ack = 1'b0;
      if (wb_req) begin
         ack_wait++;
         if (ack_wait >= ack_delay) begin
            wb_ack = 1'b1;
            if (wb_n < 64) begin
               log_set[wb_n] = wb_set;
               log_way[wb_n] = wb_way;
               log_tag[wb_n] = wb_tag;
            end
            wb_n++;
            ack_wait = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      reg_wr_en = 1'b0;
      fill_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      while (!reg_ready) @(negedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic fill(input int s, input int w, input int t, input bit d);
      @(negedge clk);
      fill_en = 1'b1;
      fill_set = IDX_W'(s);
      fill_way = WAY_W'(w);
      fill_tag = TAG_W'(t);
      fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic probe(input int s, input int w, output bit v, output bit d);
      probe_set = IDX_W'(s);
      probe_way = WAY_W'(w);
      #1;
      v = probe_valid;
      d = probe_dirty;
   endtask

   initial begin
      bit v, d;
      bit any_bad;
      do_reset();

      // R1: reset state
      chk(!busy && reg_ready && !wb_req && !inv_mode, "R1 idle", {busy, reg_ready, wb_req, inv_mode}, 4'b0100);
      any_bad = 1'b0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            probe(s, w, v, d);
            if (v || d) any_bad = 1'b1;
         end
      chk(!any_bad, "R1 lines invalid", any_bad, 0);

      // line command table: R2 R3 R4 R5 R11
      for (int k = 0; k < 8; k++) begin
         int s = (k * 3) % SETS;
         int w = k % WAYS;
         int t = 'h100 + k;
         bit inv = VEC[k][6], md = VEC[k][5], dty = VEC[k][4], mt = VEC[k][3];
         bit ewb = VEC[k][2], ev = VEC[k][1], ed = VEC[k][0];
         fill(s, w, t, dty);
         wr(A_PTAG, mt ? 32'(t) : 32'(t ^ 'h40));
         if (md) wr(A_CTRL, 32'd1);
         wb_n = 0;
         wr(inv ? A_LINV : A_LWB, 32'h8000_0000 | 32'(s << 5) | 32'h13);
         wait_idle();
         chk(wb_n == int'(ewb), $sformatf("R2/R3/R4/R5 vec%0d wb count", k), wb_n, ewb);
         if (ewb && wb_n == 1)
            chk(log_set[0] == IDX_W'(s) && log_way[0] == WAY_W'(w) && log_tag[0] == TAG_W'(t),
                $sformatf("R11 vec%0d wb fields", k), {log_set[0], log_way[0]}, {IDX_W'(s), WAY_W'(w)});
         probe(s, w, v, d);
         chk(v == ev && d == ed, $sformatf("R2/R4/R5 vec%0d line state", k), {v, d}, {ev, ed});
         if (inv) chk(!inv_mode, $sformatf("R3 vec%0d mode cleared", k), inv_mode, 0);
      end

      // R10 and R6: whole writeback
      do_reset();
      fill(2, 1, 'h21, 1'b1);
      fill(0, 3, 'h03, 1'b1);
      fill(2, 0, 'h20, 1'b0);
      fill(9, 2, 'h92, 1'b1);
      wb_n = 0;
      wr(A_AWB, 32'd2);
      repeat (3) @(negedge clk);
      chk(!busy && wb_n == 0, "R10 value 2 ignored", {busy, 8'(wb_n)}, 0);
      wr(A_AINV, 32'h3);
      repeat (3) @(negedge clk);
      probe(2, 1, v, d);
      chk(!busy && v && d, "R10 invalidate value 3 ignored", {busy, v, d}, 3'b011);
      wr(A_AWB, 32'd1);
      wait_idle();
      chk(wb_n == 3, "R6 writeback count", wb_n, 3);
      chk(log_set[0] == 0 && log_way[0] == 3 && log_tag[0] == 'h03, "R6 first", {log_set[0], log_way[0]}, 6'b0000_11);
      chk(log_set[1] == 2 && log_way[1] == 1 && log_tag[1] == 'h21, "R6 second", {log_set[1], log_way[1]}, 6'b0010_01);
      chk(log_set[2] == 9 && log_way[2] == 2 && log_tag[2] == 'h92, "R6 third", {log_set[2], log_way[2]}, 6'b1001_10);
      probe(2, 1, v, d);
      chk(v && !d, "R6 line kept clean", {v, d}, 2'b10);
      probe(2, 0, v, d);
      chk(v && !d, "R6 clean line kept", {v, d}, 2'b10);

      // R7: whole invalidate, discard mode
      fill(4, 0, 'h40, 1'b1);
      wb_n = 0;
      wr(A_AINV, 32'd1);
      wait_idle();
      chk(wb_n == 0, "R7 discard no writeback", wb_n, 0);
      any_bad = 1'b0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            probe(s, w, v, d);
            if (v) any_bad = 1'b1;
         end
      chk(!any_bad, "R7 all invalid", any_bad, 0);

      // R3 and R7: whole invalidate with writeback mode
      fill(1, 2, 'h12, 1'b1);
      fill(1, 0, 'h10, 1'b0);
      fill(7, 1, 'h71, 1'b1);
      wr(A_CTRL, 32'd1);
      chk(inv_mode, "R3 mode set", inv_mode, 1);
      wb_n = 0;
      wr(A_AINV, 32'd1);
      wait_idle();
      chk(wb_n == 2 && log_set[0] == 1 && log_way[0] == 2 && log_set[1] == 7 && log_way[1] == 1,
          "R3 whole writeback order", {log_set[0], log_way[0], log_set[1], log_way[1]}, 12'b0001_10_0111_01);
      probe(7, 1, v, d);
      chk(!v && !d, "R7 written line invalid", {v, d}, 0);
      probe(1, 0, v, d);
      chk(!v, "R7 clean line invalid", v, 0);
      chk(!inv_mode, "R3 mode cleared after whole", inv_mode, 0);

      // R8: stall while busy with slow acknowledge
      fill(3, 1, 'h31, 1'b1);
      fill(10, 2, 'hA2, 1'b1);
      ack_delay = 8;
      wr(A_PTAG, 32'h31);
      wb_n = 0;
      wr(A_LWB, 32'(3 << 5));
      chk(busy && !reg_ready, "R8 busy and stalled", {busy, reg_ready}, 2'b10);
      wr(A_AWB, 32'd1);
      wait_idle();
      chk(wb_n == 2 && log_set[1] == 10 && log_way[1] == 2, "R8 held write executed", wb_n, 2);
      chk(log_set[0] == 3 && log_way[0] == 1, "R8 line first", {log_set[0], log_way[0]}, 6'b0011_01);
      ack_delay = 1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule